// File: doc/BRIEF.md
# Debug Trace Instruction Counter

This block counts how many instructions the processor retires after it has been let out of debug mode. When the programmed budget is used up, it asks the processor to halt again. Debug software writes a step count and sets the trace enable. It then releases the processor. The block arms itself from the stored count and takes one off for every retired instruction. Instructions retired while an interrupt is being serviced count the same way. A count of N lets N+1 instructions run. The request is raised when the instruction after the budget retires.

A count of zero is normally illegal, and a write of zero is refused. When sequential-breakpoint mode is on, zero is accepted and means that a single instruction runs. The debug-entry request stays up until the processor acknowledges that it has halted. A sticky trace-hit flag records that the trace count caused the halt. A two-bit mode field reports whether the processor is running, has a halt pending, or is halted. If the halt-on-reset control is set while reset is applied, the block comes out of reset in the halted state.

Top module: `trace_step_counter`

## Requirements
- R1: While `rst_n` is low (synchronous reset), the block goes to a state with `dbg_req`=0, `trace_hit`=0 and `load_err`=0. The stored count becomes 1. `cpu_mode` becomes 2'b10 if `ctl_halt_on_reset` is 1, and 2'b00 otherwise.
- R2: A count write of zero while `ctl_seq_mode`=0 is refused: the stored count does not change and `load_err` goes to 1. Any accepted write clears `load_err` on the next cycle.
- R3: With `ctl_seq_mode`=1 a zero count is accepted, and the request is raised on the first retired instruction after the release.
- R4: With a stored count of N≥1, `dbg_req` rises on the cycle after the (N+1)th `retire` strobe that follows an armed release. With N=1 that is two instructions.
- R5: A `retire` strobe does not change the remaining count in any of these cases: while halted, while a request is pending, or after a release with `ctl_trace_en`=0. With the trace disabled, no request ever appears.
- R6: `dbg_req` stays at 1 until `dbg_ack` is seen. On the cycle after the acknowledge, `dbg_req` is 0 and `cpu_mode` is 2'b10.
- R7: `trace_hit` rises together with a count-caused `dbg_req`. It stays set across later releases and retires, and it clears on the cycle after `stat_access`. If a count expiry and `stat_access` fall in the same cycle, the expiry wins.
- R8: The `cpu_mode` encoding is 2'b00 running, 2'b01 halt requested and 2'b10 halted. `dbg_exit` is acted on only in the 2'b10 state, where it moves the mode to 2'b00.
- R9: Each release with `ctl_trace_en`=1 reloads the remaining count from the stored value, so repeated releases give the same number of instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_wr_en | input | 1 | Count register write strobe |
| cnt_wr_data | input | CNT_W | Count value to write |
| ctl_trace_en | input | 1 | Trace mode enable |
| ctl_seq_mode | input | 1 | Sequential-breakpoint mode, allows a zero count |
| ctl_halt_on_reset | input | 1 | Enter the halted state out of reset |
| retire | input | 1 | One instruction retired this cycle |
| dbg_exit | input | 1 | Processor released from debug mode |
| dbg_ack | input | 1 | Processor has entered debug mode |
| stat_access | input | 1 | Status read or write, clears trace_hit |
| dbg_req | output | 1 | Debug-entry request |
| trace_hit | output | 1 | Sticky flag: halt caused by the trace count |
| cpu_mode | output | 2 | Processor mode status |
| load_err | output | 1 | Last count write was refused |

## Verification
A remaining count that is off by one or decrements at the wrong time shows up as `dbg_req` rising one cycle early or late. It is therefore exposed on the first trace whose expiry the bench is waiting for. A wrong mode or arming bit shows in `cpu_mode` on the very next cycle. It also shows as a request that appears while the trace is disabled, or never appears. Errors in the sticky flags and the load check show up in `trace_hit` and `load_err` on the cycle after the event that should have changed them. The behavioural model is compared against every output on every cycle, so such an error is reported within a cycle or two of the event.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
   typedef enum logic [1:0] {
      MODE_RUN  = 2'b00,
      MODE_REQ  = 2'b01,
      MODE_HALT = 2'b10
   } trc_mode_e;
endpackage

// File: rtl/trc_count_reg.sv
`timescale 1ns/1ps
// Stored step budget with legality check on write.
module trc_count_reg #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             seq_mode,
   output logic [CNT_W-1:0] count_q,
   output logic             err_q
);
   localparam logic [CNT_W-1:0] RST_COUNT = CNT_W'(1);

   logic is_zero;
   logic accept;

   assign is_zero = (wr_data == '0);
   assign accept  = wr_en && (!is_zero || seq_mode);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= RST_COUNT;
         err_q   <= 1'b0;
      end else if (accept) begin
         count_q <= wr_data;
         err_q   <= 1'b0;
      end else if (wr_en) begin
         err_q   <= 1'b1;
      end
   end

   AST_ZERO_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && is_zero && !seq_mode |=> $stable(count_q) && err_q); // R2
   AST_ZERO_SEQ_OK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && is_zero && seq_mode |=> (count_q == '0) && !err_q); // R3
endmodule

// File: rtl/trc_down_counter.sv
`timescale 1ns/1ps
// Remaining-instruction counter, armed on release, expires one past zero.
module trc_down_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic             fire
);
   localparam logic [CNT_W-1:0] DEC = CNT_W'(1);

   logic [CNT_W-1:0] rem_q;
   logic             armed_q;
   logic             at_zero;

   assign at_zero = (rem_q == '0);
   assign fire    = armed_q && step && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q   <= '0;
         armed_q <= 1'b0;
      end else if (arm) begin
         rem_q   <= load_val;
         armed_q <= 1'b1;
      end else if (armed_q && step) begin
         if (at_zero) armed_q <= 1'b0;
         else         rem_q   <= rem_q - DEC;
      end
   end

   AST_EXPIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !arm |=> !armed_q); // R4
   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q && !arm |=> !armed_q); // R5
   AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step && !arm |=> $stable(rem_q)); // R5
   AST_ARM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> armed_q && (rem_q == $past(load_val))); // R9
endmodule

// File: rtl/trc_mode_ctl.sv
`timescale 1ns/1ps
// Processor mode tracking: running, halt requested, halted.
module trc_mode_ctl
   import trc_pkg::*;
#(
   parameter bit RESET_HALT_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      halt_on_reset,
   input  logic      fire,
   input  logic      dbg_ack,
   input  logic      dbg_exit,
   output trc_mode_e mode_q,
   output logic      exit_ok
);
   trc_mode_e rst_mode;
   trc_mode_e mode_d;

   generate
      if (RESET_HALT_EN) begin : g_rst_halt
         assign rst_mode = halt_on_reset ? MODE_HALT : MODE_RUN;
      end else begin : g_rst_run
         assign rst_mode = MODE_RUN;
      end
   endgenerate

   assign exit_ok = dbg_exit && (mode_q == MODE_HALT);

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_RUN:  if (fire)    mode_d = MODE_REQ;
         MODE_REQ:  if (dbg_ack) mode_d = MODE_HALT;
         MODE_HALT: if (exit_ok) mode_d = MODE_RUN;
         default:                mode_d = MODE_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= rst_mode;
      else        mode_q <= mode_d;
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == MODE_REQ && !dbg_ack |=> mode_q == MODE_REQ); // R6
   AST_ACK_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == MODE_REQ && dbg_ack |=> mode_q == MODE_HALT); // R6
   AST_EXIT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == MODE_HALT && dbg_exit |=> mode_q == MODE_RUN); // R8
   AST_HALT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == MODE_HALT && !dbg_exit |=> mode_q == MODE_HALT); // R8
endmodule

// File: rtl/trace_step_counter.sv
`timescale 1ns/1ps
// Debug trace instruction counter top.
module trace_step_counter
   import trc_pkg::*;
#(
   parameter int CNT_W         = 16,
   parameter bit RESET_HALT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_wr_en,
   input  logic [CNT_W-1:0] cnt_wr_data,
   input  logic             ctl_trace_en,
   input  logic             ctl_seq_mode,
   input  logic             ctl_halt_on_reset,
   input  logic             retire,
   input  logic             dbg_exit,
   input  logic             dbg_ack,
   input  logic             stat_access,
   output logic             dbg_req,
   output logic             trace_hit,
   output logic [1:0]       cpu_mode,
   output logic             load_err
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("trace_step_counter: CNT_W must lie in 2..32");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;
   trc_mode_e        mode_q;
   logic             exit_ok;
   logic             arm;
   logic             step;
   logic             fire;
   logic             hit_q;

   trc_count_reg #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cnt_wr_en),
      .wr_data  (cnt_wr_data),
      .seq_mode (ctl_seq_mode),
      .count_q  (count_q),
      .err_q    (load_err)
   );

   assign arm  = exit_ok && ctl_trace_en;
   assign step = retire && (mode_q == MODE_RUN);

   trc_down_counter #(.CNT_W(CNT_W)) u_down (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .load_val (count_q),
      .step     (step),
      .fire     (fire)
   );

   trc_mode_ctl #(.RESET_HALT_EN(RESET_HALT_EN)) u_mode (
      .clk           (clk),
      .rst_n         (rst_n),
      .halt_on_reset (ctl_halt_on_reset),
      .fire          (fire),
      .dbg_ack       (dbg_ack),
      .dbg_exit      (dbg_exit),
      .mode_q        (mode_q),
      .exit_ok       (exit_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)           hit_q <= 1'b0;
      else if (fire)        hit_q <= 1'b1;
      else if (stat_access) hit_q <= 1'b0;
   end

   assign trace_hit = hit_q;
   assign dbg_req   = (mode_q == MODE_REQ);
   assign cpu_mode  = mode_q;

   AST_HIT_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> trace_hit && dbg_req); // R7
   AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      trace_hit && !stat_access |=> trace_hit); // R7
   AST_HIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      stat_access && !fire |=> !trace_hit); // R7
   AST_NO_TRACE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      exit_ok && !ctl_trace_en |=> !dbg_req); // R5
   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_mode != 2'b11); // R8
endmodule

// File: tb/sim_trace_step_counter.sv
`timescale 1ns/1ps
module sim_trace_step_counter;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_wr_en = 1'b0;
   logic [W-1:0] cnt_wr_data = '0;
   logic         ctl_trace_en = 1'b0, ctl_seq_mode = 1'b0, ctl_halt_on_reset = 1'b1;
   logic         retire = 1'b0, dbg_exit = 1'b0, dbg_ack = 1'b0, stat_access = 1'b0;
   logic         dbg_req, trace_hit, load_err;
   logic [1:0]   cpu_mode;

   int n_chk = 0, n_fail = 0;
   bit started = 0, done = 0;

   always #2 clk = ~clk;

   trace_step_counter #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
      .ctl_trace_en(ctl_trace_en), .ctl_seq_mode(ctl_seq_mode),
      .ctl_halt_on_reset(ctl_halt_on_reset), .retire(retire), .dbg_exit(dbg_exit),
      .dbg_ack(dbg_ack), .stat_access(stat_access), .dbg_req(dbg_req),
      .trace_hit(trace_hit), .cpu_mode(cpu_mode), .load_err(load_err));

   // Behavioural reference: mode 0 run, 1 requested, 2 halted.
   int m_budget = 1, m_left = 0, m_mode = 0;
   bit m_live = 0, m_hit = 0, m_err = 0;

   always @(posedge clk) begin
      int budget_old;
      bit expired;
      started = 1;
      if (!rst_n) begin
         m_budget = 1; m_left = 0; m_live = 0; m_hit = 0; m_err = 0;
         m_mode = ctl_halt_on_reset ? 2 : 0;
      end else begin
         budget_old = m_budget;
         expired = m_live && retire && m_mode == 0 && m_left == 0;
         if (cnt_wr_en) begin
            if (cnt_wr_data != 0 || ctl_seq_mode) begin
               m_budget = int'(cnt_wr_data); m_err = 0;
            end else m_err = 1;
         end
         if (dbg_exit && m_mode == 2 && ctl_trace_en) begin
            m_live = 1; m_left = budget_old;
         end else if (m_live && retire && m_mode == 0) begin
            if (m_left == 0) m_live = 0; else m_left = m_left - 1;
         end
         if (expired) m_hit = 1; else if (stat_access) m_hit = 0;
         if (m_mode == 0 && expired) m_mode = 1;
         else if (m_mode == 1 && dbg_ack) m_mode = 2;
         else if (m_mode == 2 && dbg_exit) m_mode = 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started && !done) begin
         chk(dbg_req == (m_mode == 1), "R6 dbg_req vs model", int'(dbg_req), int'(m_mode == 1));
         chk(trace_hit == m_hit, "R7 trace_hit vs model", int'(trace_hit), int'(m_hit));
         chk(int'(cpu_mode) == m_mode, "R8 cpu_mode vs model", int'(cpu_mode), m_mode);
         chk(load_err == m_err, "R2 load_err vs model", int'(load_err), int'(m_err));
      end
   end

   task automatic cyc(input bit r, input bit x, input bit a, input bit s);
      retire = r; dbg_exit = x; dbg_ack = a; stat_access = s;
      @(negedge clk);
      retire = 0; dbg_exit = 0; dbg_ack = 0; stat_access = 0;
   endtask

   task automatic wr(input int d, input bit seq);
      ctl_seq_mode = seq; cnt_wr_en = 1; cnt_wr_data = W'(d);
      @(negedge clk);
      cnt_wr_en = 0;
   endtask

   task automatic do_reset(input bit halt);
      ctl_halt_on_reset = halt; rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   // Retires (optionally every other cycle) until dbg_req; returns the count.
   task automatic run_to_req(input bit gaps, input bit stat_last, output int n);
      n = 0;
      for (int i = 0; i < 60; i++) begin
         n++;
         cyc(1, 0, 0, stat_last);
         if (dbg_req) break;
         if (gaps) cyc(0, 0, 0, 0);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int n;
      @(negedge clk);
      do_reset(1);
      chk(cpu_mode == 2'b10, "R1 reset halted mode", int'(cpu_mode), 2);
      chk(!dbg_req && !trace_hit && !load_err, "R1 reset flags", int'(dbg_req), 0);

      wr(0, 0);
      chk(load_err == 1, "R2 zero refused", int'(load_err), 1);
      // With the zero refused, the reset count of 1 must still give two instructions.
      ctl_trace_en = 1;
      cyc(0, 1, 0, 0);
      run_to_req(0, 0, n);
      chk(n == 2, "R2 count kept after refusal", n, 2);
      cyc(0, 0, 1, 0);
      wr(3, 0);
      chk(load_err == 0, "R2 accepted write clears error", int'(load_err), 0);

      cyc(0, 1, 0, 0);
      chk(cpu_mode == 2'b00, "R8 release to run", int'(cpu_mode), 0);
      run_to_req(0, 0, n);
      chk(n == 4, "R4 count 3 gives 4 instructions", n, 4);
      chk(trace_hit == 1, "R7 hit with request", int'(trace_hit), 1);
      repeat (3) cyc(1, 0, 0, 0);
      chk(dbg_req == 1 && cpu_mode == 2'b01, "R6 request held", int'(cpu_mode), 1);
      cyc(0, 0, 1, 0);
      chk(dbg_req == 0 && cpu_mode == 2'b10, "R6 ack halts", int'(cpu_mode), 2);
      repeat (3) cyc(1, 0, 0, 0);
      chk(cpu_mode == 2'b10, "R5 retire ignored while halted", int'(cpu_mode), 2);

      cyc(0, 1, 0, 0);
      chk(trace_hit == 1, "R7 hit survives release", int'(trace_hit), 1);
      run_to_req(1, 0, n);
      chk(n == 4, "R9 reload repeats count", n, 4);
      cyc(0, 0, 1, 0);
      cyc(0, 0, 0, 1);
      chk(trace_hit == 0, "R7 status access clears", int'(trace_hit), 0);

      wr(0, 1);
      chk(load_err == 0, "R3 zero accepted in seq mode", int'(load_err), 0);
      cyc(0, 1, 0, 0);
      run_to_req(0, 0, n);
      chk(n == 1, "R3 zero gives one instruction", n, 1);
      cyc(0, 0, 1, 0);

      ctl_trace_en = 0;
      cyc(0, 1, 0, 0);
      repeat (10) cyc(1, 0, 0, 0);
      chk(dbg_req == 0 && cpu_mode == 2'b00, "R5 no request when trace off", int'(dbg_req), 0);

      do_reset(0);
      chk(cpu_mode == 2'b00, "R1 reset running mode", int'(cpu_mode), 0);
      do_reset(1);
      wr(1, 0);
      ctl_trace_en = 1;
      cyc(0, 1, 0, 0);
      run_to_req(0, 0, n);
      chk(n == 2, "R4 minimum count 1 gives 2", n, 2);
      cyc(0, 0, 1, 0);
      cyc(0, 0, 0, 1);
      cyc(0, 1, 0, 0);
      run_to_req(0, 1, n);
      chk(trace_hit == 1, "R7 expiry beats clear", int'(trace_hit), 1);
      cyc(0, 0, 1, 0);

      for (int k = 0; k < 4000; k++) begin
         if ($urandom_range(0, 499) == 0) do_reset(1'($urandom_range(0, 1)));
         ctl_trace_en = ($urandom_range(0, 9) < 8);
         if ($urandom_range(0, 19) == 0) wr(int'($urandom_range(0, 5)), 1'($urandom_range(0, 2) == 0));
         cyc($urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0,
             $urandom_range(0, 4) == 0, $urandom_range(0, 19) == 0);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule